// File: doc/BRIEF.md
# Short-Vector Register Sequencer

This block turns one short-vector floating-point request into a series of scalar operations. It receives a destination register number, two source register numbers, a length field and a stride field. It then presents one register triple per cycle to a scalar operation unit over a valid/ready port. A register number is five bits wide: the upper two bits name one of four banks and the lower three bits name one of eight registers inside that bank. Stepping through a vector wraps inside the bank and never crosses into the next bank.

The operation unit returns its exception flags and its comparison flags in the same cycle that it accepts a triple. The sequencer ORs the exception flags across all elements. It ends the run when the element count is reached or when an element returns nonzero comparison flags. At the end it raises a one-cycle done pulse and presents the collected exceptions and the final comparison flags. A destination in bank 0 makes the request scalar. A second source in bank 0 stays put, which mixes a scalar operand into a vector operation. For the extension class of operations the first-source field carries a sub-operation code, so it is held constant.

Top module: `vecseq_top`

## Requirements
- R1: Bits [4:3] of a register number are its bank and bits [2:0] its index. Each step adds the stride to the index modulo 8 (7 + 1 wraps to 0 and 7 + 2 to 1), and the bank bits never change during a run.
- R2: The stride is 2 when the 2-bit stride field is 2'b11, and 1 for 2'b00, 2'b01 and 2'b10.
- R3: When the destination bank is nonzero, exactly len + 1 triples are issued for the 3-bit length field len, so 1 to 8 triples.
- R4: When the destination bank is 0, exactly one triple is issued, whatever the length field holds.
- R5: A second source in bank 0 keeps the same value on every triple. A second source in any other bank steps like the destination.
- R6: When ext_i is 1 at start, the first-source field keeps its start value on every triple and iss_ext_o is 1. When ext_i is 0 the first source steps like the destination, in any bank.
- R7: The exception flags returned with every accepted triple are ORed together and shown on done_exc_o at the done pulse. Nonzero exception flags do not end the run.
- R8: If an accepted triple returns nonzero comparison flags, no further triple is issued, done follows in the next cycle, and done_flags_o shows those flags.
- R9: While iss_valid_o is 1 and iss_ready_i is 0, the triple on the issue port holds steady and no element is skipped.
- R10: done_o is high for exactly one cycle, in the cycle after the final accepted triple, with busy_o and iss_valid_o low. done_exc_o and done_flags_o keep their values until the next accepted start.
- R11: A start_i pulse while busy_o is 1 is ignored, and the current run continues with its own registers and count.
- R12: After reset, iss_valid_o, busy_o and done_o are 0 and done_exc_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| ext_i | input | 1 | Extension-class operation; the first-source field is a sub-operation code |
| dst_i | input | 5 | Starting destination register |
| srca_i | input | 5 | Starting first-source register or sub-operation code |
| srcb_i | input | 5 | Starting second-source register |
| len_i | input | 3 | Length field (element count minus one) |
| stride_i | input | 2 | Stride field (2'b11 selects stride 2) |
| busy_o | output | 1 | A run is in progress |
| iss_valid_o | output | 1 | Issue triple is valid |
| iss_ready_i | input | 1 | Operation unit accepts the triple |
| iss_dst_o | output | 5 | Issued destination register |
| iss_srca_o | output | 5 | Issued first-source register or sub-operation code |
| iss_srcb_o | output | 5 | Issued second-source register |
| iss_ext_o | output | 1 | Issued operation is of the extension class |
| iss_exc_i | input | 5 | Exception flags returned with an accepted triple |
| iss_flags_i | input | 4 | Comparison flags returned with an accepted triple |
| done_o | output | 1 | One-cycle end-of-run pulse |
| done_exc_o | output | 5 | ORed exception flags of the run |
| done_flags_o | output | 4 | Comparison flags of the last accepted triple |

## Verification
Two ends of a run can fall on the same element. The count can run out on the very triple that returns comparison flags and exceptions, and a new start can arrive in that same final handshake cycle. The bench provokes both together on a two-element run. It judges that exactly two triples are issued and that the done pulse carries both the ORed exceptions and the comparison flags. It also judges that the start seen during that busy handshake cycle does not open a new run after done.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;

    // Run phase of the sequencer
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } seq_phase_e;

endpackage

// File: rtl/vecseq_idx_step.sv
// Advances one register number by the stride inside its bank.
module vecseq_idx_step #(
    parameter int REG_W         = 5,
    parameter int IDX_W         = 3,
    parameter bit HOLD_IN_BANK0 = 1'b0
) (
    input  logic [REG_W-1:0] cur_i,
    input  logic             stride2_i,
    input  logic             freeze_i,
    output logic [REG_W-1:0] nxt_o
);
    localparam int BANK_W = REG_W - IDX_W;

    logic [IDX_W-1:0]  step;
    logic [IDX_W-1:0]  idx_sum;
    logic [BANK_W-1:0] bank;
    logic              hold;

    assign bank    = cur_i[REG_W-1:IDX_W];
    assign step    = stride2_i ? IDX_W'(2) : IDX_W'(1);
    assign idx_sum = cur_i[IDX_W-1:0] + step;

    generate
        if (HOLD_IN_BANK0) begin : g_hold_bank0
            assign hold = freeze_i | (bank == '0);
        end else begin : g_always_step
            assign hold = freeze_i;
        end
    endgenerate

    assign nxt_o = hold ? cur_i : {bank, idx_sum};

endmodule

// File: rtl/vecseq_len_dec.sv
// Decodes the control fields into an element count and a stride select.
module vecseq_len_dec #(
    parameter int REG_W    = 5,
    parameter int IDX_W    = 3,
    parameter int LEN_W    = 3,
    parameter int STRIDE_W = 2
) (
    input  logic [REG_W-1:0]    dst_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [LEN_W:0]      count_o,
    output logic                stride2_o
);
    localparam int CNT_W = LEN_W + 1;

    logic scalar_dst;

    assign scalar_dst = (dst_i[REG_W-1:IDX_W] == '0);
    assign stride2_o  = &stride_i;
    assign count_o    = scalar_dst ? CNT_W'(1) : ({1'b0, len_i} + CNT_W'(1));

endmodule

// File: rtl/vecseq_top.sv
module vecseq_top #(
    parameter int REG_W    = 5,
    parameter int IDX_W    = 3,
    parameter int LEN_W    = 3,
    parameter int STRIDE_W = 2,
    parameter int EXC_W    = 5,
    parameter int FLAG_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                ext_i,
    input  logic [REG_W-1:0]    dst_i,
    input  logic [REG_W-1:0]    srca_i,
    input  logic [REG_W-1:0]    srcb_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic                busy_o,
    output logic                iss_valid_o,
    input  logic                iss_ready_i,
    output logic [REG_W-1:0]    iss_dst_o,
    output logic [REG_W-1:0]    iss_srca_o,
    output logic [REG_W-1:0]    iss_srcb_o,
    output logic                iss_ext_o,
    input  logic [EXC_W-1:0]    iss_exc_i,
    input  logic [FLAG_W-1:0]   iss_flags_i,
    output logic                done_o,
    output logic [EXC_W-1:0]    done_exc_o,
    output logic [FLAG_W-1:0]   done_flags_o
);
    import vecseq_pkg::*;

    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        seq_phase_e        phase;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  srca;
        logic [REG_W-1:0]  srcb;
        logic              ext;
        logic              stride2;
        logic [CNT_W-1:0]  rem;
        logic [EXC_W-1:0]  exc;
        logic [FLAG_W-1:0] flags;
        logic              done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [CNT_W-1:0] count_dec;
    logic             stride2_dec;
    logic [REG_W-1:0] dst_nxt;
    logic [REG_W-1:0] srca_nxt;
    logic [REG_W-1:0] srcb_nxt;
    logic             fire;
    logic             last_elem;

    vecseq_len_dec #(
        .REG_W    (REG_W),
        .IDX_W    (IDX_W),
        .LEN_W    (LEN_W),
        .STRIDE_W (STRIDE_W)
    ) i_len_dec (
        .dst_i     (dst_i),
        .len_i     (len_i),
        .stride_i  (stride_i),
        .count_o   (count_dec),
        .stride2_o (stride2_dec)
    );

    // Destination always steps inside its bank
    vecseq_idx_step #(
        .REG_W         (REG_W),
        .IDX_W         (IDX_W),
        .HOLD_IN_BANK0 (1'b0)
    ) i_step_dst (
        .cur_i     (st_q.dst),
        .stride2_i (st_q.stride2),
        .freeze_i  (1'b0),
        .nxt_o     (dst_nxt)
    );

    // First source holds when it carries a sub-operation code
    vecseq_idx_step #(
        .REG_W         (REG_W),
        .IDX_W         (IDX_W),
        .HOLD_IN_BANK0 (1'b0)
    ) i_step_srca (
        .cur_i     (st_q.srca),
        .stride2_i (st_q.stride2),
        .freeze_i  (st_q.ext),
        .nxt_o     (srca_nxt)
    );

    // Second source holds in bank 0 (scalar operand)
    vecseq_idx_step #(
        .REG_W         (REG_W),
        .IDX_W         (IDX_W),
        .HOLD_IN_BANK0 (1'b1)
    ) i_step_srcb (
        .cur_i     (st_q.srcb),
        .stride2_i (st_q.stride2),
        .freeze_i  (1'b0),
        .nxt_o     (srcb_nxt)
    );

    assign fire      = (st_q.phase == PH_RUN) && iss_ready_i;
    assign last_elem = (st_q.rem == CNT_W'(1)) || (iss_flags_i != '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase   = PH_RUN;
                    st_d.dst     = dst_i;
                    st_d.srca    = srca_i;
                    st_d.srcb    = srcb_i;
                    st_d.ext     = ext_i;
                    st_d.stride2 = stride2_dec;
                    st_d.rem     = count_dec;
                    st_d.exc     = '0;
                    st_d.flags   = '0;
                end
            end
            PH_RUN: begin
                if (fire) begin
                    st_d.exc   = st_q.exc | iss_exc_i;
                    st_d.flags = iss_flags_i;
                    if (last_elem) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.rem  = st_q.rem - CNT_W'(1);
                        st_d.dst  = dst_nxt;
                        st_d.srca = srca_nxt;
                        st_d.srcb = srcb_nxt;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = (st_q.phase == PH_RUN);
    assign iss_valid_o  = (st_q.phase == PH_RUN);
    assign iss_dst_o    = st_q.dst;
    assign iss_srca_o   = st_q.srca;
    assign iss_srcb_o   = st_q.srcb;
    assign iss_ext_o    = st_q.ext;
    assign done_o       = st_q.done;
    assign done_exc_o   = st_q.exc;
    assign done_flags_o = st_q.flags;

endmodule

// File: rtl/vecseq_chk.sv
module vecseq_chk #(
    parameter int REG_W  = 5,
    parameter int IDX_W  = 3,
    parameter int FLAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              iss_valid_o,
    input logic              iss_ready_i,
    input logic [REG_W-1:0]  iss_dst_o,
    input logic [REG_W-1:0]  iss_srca_o,
    input logic [REG_W-1:0]  iss_srcb_o,
    input logic              iss_ext_o,
    input logic [FLAG_W-1:0] iss_flags_i,
    input logic              done_o
);
    logic hs;
    assign hs = iss_valid_o && iss_ready_i;

    AST_BANK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> !iss_valid_o ||
               (iss_dst_o[REG_W-1:IDX_W]  == $past(iss_dst_o[REG_W-1:IDX_W]) &&
                iss_srca_o[REG_W-1:IDX_W] == $past(iss_srca_o[REG_W-1:IDX_W]) &&
                iss_srcb_o[REG_W-1:IDX_W] == $past(iss_srcb_o[REG_W-1:IDX_W]))); // R1

    AST_SCALAR_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && iss_dst_o[REG_W-1:IDX_W] == '0) |=> !iss_valid_o); // R4

    AST_SRCB_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && iss_srcb_o[REG_W-1:IDX_W] == '0) |=> !iss_valid_o || $stable(iss_srcb_o)); // R5

    AST_EXT_SRCA: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && iss_ext_o) |=> !iss_valid_o || $stable(iss_srca_o)); // R6

    AST_CMP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && iss_flags_i != '0) |=> !iss_valid_o && done_o); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && !iss_ready_i) |=> iss_valid_o && $stable(iss_dst_o) &&
                                          $stable(iss_srca_o) && $stable(iss_srcb_o)); // R9

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !iss_valid_o); // R10

endmodule

bind vecseq_top vecseq_chk #(
    .REG_W  (REG_W),
    .IDX_W  (IDX_W),
    .FLAG_W (FLAG_W)
) i_vecseq_chk (.*);

// File: tb/test_vecseq_top.sv
module test_vecseq_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0] d;
        logic [4:0] a;
        logic [4:0] b;
        logic       ext;
        logic [2:0] len;
        logic [1:0] stride;
        logic [3:0] n_exp;
    } vec_t;

    localparam vec_t [0:7] VECS = '{
        '{5'd8,  5'd16, 5'd24, 1'b0, 3'd3, 2'b00, 4'd4}, // R3 R1 all vector
        '{5'd15, 5'd23, 5'd31, 1'b0, 3'd2, 2'b11, 4'd3}, // R2 R1 stride 2, wrap
        '{5'd0,  5'd8,  5'd16, 1'b0, 3'd5, 2'b01, 4'd1}, // R4 scalar destination
        '{5'd12, 5'd20, 5'd3,  1'b0, 3'd3, 2'b01, 4'd4}, // R5 scalar second source
        '{5'd9,  5'd5,  5'd17, 1'b1, 3'd2, 2'b00, 4'd3}, // R6 sub-operation held
        '{5'd26, 5'd10, 5'd28, 1'b0, 3'd7, 2'b10, 4'd8}, // R2 R3 full length, stride 1
        '{5'd2,  5'd9,  5'd18, 1'b0, 3'd7, 2'b11, 4'd1}, // R4 bank 0, max length
        '{5'd31, 5'd1,  5'd7,  1'b0, 3'd1, 2'b11, 4'd2}  // R1 R5 R6 bank-0 first source steps
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ext_i = 1'b0;
    logic [4:0] dst_i = '0, srca_i = '0, srcb_i = '0;
    logic [2:0] len_i = '0;
    logic [1:0] stride_i = '0;
    logic       iss_ready_i = 1'b0;
    logic [4:0] iss_exc_i = '0;
    logic [3:0] iss_flags_i = '0;
    logic       busy_o, iss_valid_o, iss_ext_o, done_o;
    logic [4:0] iss_dst_o, iss_srca_o, iss_srcb_o, done_exc_o;
    logic [3:0] done_flags_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vecseq_top i_vecseq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_i(ext_i),
        .dst_i(dst_i), .srca_i(srca_i), .srcb_i(srcb_i), .len_i(len_i),
        .stride_i(stride_i), .busy_o(busy_o), .iss_valid_o(iss_valid_o),
        .iss_ready_i(iss_ready_i), .iss_dst_o(iss_dst_o), .iss_srca_o(iss_srca_o),
        .iss_srcb_o(iss_srcb_o), .iss_ext_o(iss_ext_o), .iss_exc_i(iss_exc_i),
        .iss_flags_i(iss_flags_i), .done_o(done_o), .done_exc_o(done_exc_o),
        .done_flags_o(done_flags_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] adv(input logic [4:0] r, input bit s2, input bit hold);
        return hold ? r : {r[4:3], r[2:0] + (s2 ? 3'd2 : 3'd1)};
    endfunction

    task automatic kick(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                        input bit ext, input logic [2:0] len, input logic [1:0] str);
        @(negedge clk);
        start_i = 1'b1; dst_i = d; srca_i = a; srcb_i = b;
        ext_i = ext; len_i = len; stride_i = str;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [4:0] ed, ea, eb, eexc;
        bit s2;
        int k;
        ed = v.d; ea = v.a; eb = v.b; eexc = '0; s2 = (v.stride == 2'b11); k = 0;
        kick(v.d, v.a, v.b, v.ext, v.len, v.stride);
        while (iss_valid_o && k < 16) begin
            chk(iss_dst_o == ed,  "R1 R2 dst index",  iss_dst_o,  ed);
            chk(iss_srca_o == ea, "R6 srca index",    iss_srca_o, ea);
            chk(iss_srcb_o == eb, "R5 srcb index",    iss_srcb_o, eb);
            iss_exc_i = 5'(1 << (k % 5));
            eexc = eexc | iss_exc_i;
            iss_ready_i = 1'b1;
            @(negedge clk);
            ed = adv(ed, s2, 1'b0);
            ea = adv(ea, s2, v.ext);
            eb = adv(eb, s2, eb[4:3] == 2'b00);
            k++;
        end
        iss_ready_i = 1'b0; iss_exc_i = '0;
        chk(k == int'(v.n_exp), "R3 R4 element count", k, v.n_exp);
        chk(done_o == 1'b1, "R10 done after last", done_o, 1);
        chk(done_exc_o == eexc, "R7 ORed exceptions", done_exc_o, eexc);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(iss_valid_o == 0 && busy_o == 0, "R12 idle after reset", {busy_o, iss_valid_o}, 0);
        chk(done_o == 0, "R12 no done after reset", done_o, 0);
        chk(done_exc_o == 0, "R12 exceptions clear", done_exc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(iss_valid_o == 0, "R12 idle without start", iss_valid_o, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R9 stall holds the triple
        kick(5'd8, 5'd16, 5'd24, 1'b0, 3'd1, 2'b00);
        for (int s = 0; s < 2; s++) begin
            chk(iss_valid_o == 1 && iss_dst_o == 5'd8, "R9 held during stall", iss_dst_o, 8);
            @(negedge clk);
        end
        iss_ready_i = 1'b1;
        @(negedge clk);
        chk(iss_valid_o == 1 && iss_dst_o == 5'd9, "R9 next element after stall", iss_dst_o, 9);
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk(done_o == 1, "R9 run ends after two", done_o, 1);
        @(negedge clk);

        // R11 start while busy is ignored
        kick(5'd16, 5'd16, 5'd16, 1'b0, 3'd2, 2'b00);
        start_i = 1'b1; dst_i = 5'd30;
        iss_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(iss_dst_o == 5'd17, "R11 run continues", iss_dst_o, 17);
        @(negedge clk);
        chk(iss_dst_o == 5'd18, "R11 original count kept", iss_dst_o, 18);
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk(done_o == 1, "R11 done after three", done_o, 1);
        @(negedge clk);

        // R7 R8 exception does not stop; compare does
        kick(5'd8, 5'd16, 5'd24, 1'b0, 3'd7, 2'b00);
        iss_ready_i = 1'b1; iss_exc_i = 5'b00001; iss_flags_i = 4'b0000;
        @(negedge clk);
        chk(iss_valid_o == 1, "R7 exception keeps running", iss_valid_o, 1);
        iss_exc_i = 5'b00010; iss_flags_i = 4'b0100;
        @(negedge clk);
        iss_ready_i = 1'b0; iss_exc_i = '0; iss_flags_i = '0;
        chk(iss_valid_o == 0 && done_o == 1, "R8 compare stops", {iss_valid_o, done_o}, 1);
        chk(done_flags_o == 4'b0100, "R8 flags reported", done_flags_o, 4'b0100);
        chk(done_exc_o == 5'b00011, "R7 exceptions ORed", done_exc_o, 5'b00011);
        @(negedge clk);
        chk(done_o == 0, "R10 one-cycle pulse", done_o, 0);
        chk(done_exc_o == 5'b00011, "R10 exceptions held", done_exc_o, 5'b00011);

        // Count end and compare stop on the same element, with a start during the final handshake
        kick(5'd8, 5'd16, 5'd24, 1'b0, 3'd1, 2'b00);
        iss_ready_i = 1'b1; iss_exc_i = 5'b00100;
        @(negedge clk);
        iss_exc_i = 5'b10000; iss_flags_i = 4'b1000;
        start_i = 1'b1; dst_i = 5'd24;
        @(negedge clk);
        start_i = 1'b0; iss_ready_i = 1'b0; iss_exc_i = '0; iss_flags_i = '0;
        chk(done_o == 1 && busy_o == 0, "R10 R8 done on last compare", {done_o, busy_o}, 2);
        chk(done_exc_o == 5'b10100, "R7 both exceptions", done_exc_o, 5'b10100);
        chk(done_flags_o == 4'b1000, "R8 last flags", done_flags_o, 4'b1000);
        @(negedge clk);
        chk(iss_valid_o == 0, "R11 busy start not taken", iss_valid_o, 0);
        chk(done_flags_o == 4'b1000, "R10 flags held", done_flags_o, 4'b1000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule